// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block serves 32-bit reads from a memory-mapped bus window by running a SPI flash read transaction for each one. One setup word per chip select holds the read opcode, the address length, the dummy length and the data line mode, so flashes with different read commands can share the port. A switch bit hands the SPI port to memory-mapped mode. While the bit is clear, the port belongs to command mode, and mapped reads are refused with an error.

For each accepted read, the engine pulls the chosen chip select low. It then shifts out the opcode and the window offset as the flash address on a single line. Next it idles for the dummy clocks with every line released. Finally it clocks in four bytes on one, two or four lines and packs them into a little-endian word. The bus waits until the word is complete.

The sequencer states are IDLE (port quiet, waiting for a request), HDR (opcode and address bits out on io0), DUMMY (clocks with all lines released), DATA (input beats), FIN (chip select released, word and done returned) and ERR (error response, no SPI activity). The transitions are these:
- IDLE goes to ERR on a refused request and to HDR on an accepted one.
- HDR goes to DUMMY when the setup asks for dummy bytes, and to DATA otherwise.
- DUMMY goes to DATA.
- DATA goes to FIN.
- FIN and ERR go back to IDLE.

SCLK runs at half the clock rate in SPI mode 0. The flash samples on the rising edge, and the engine samples input data at the end of the high phase.

Top module: `mmspi_read_engine`

## Requirements
- R1: After reset, every chip select is high, SCLK is low, no io line is driven, bus_done and bus_err are low and the switch bit is clear.
- R2: A request made while the switch bit is clear gets bus_done and bus_err together in the cycle after it is accepted. No chip select falls and no SCLK edge occurs.
- R3: The transaction starts with the 8-bit opcode from setup bits 7:0, MSB first, on io0 alone. io0 is the only line driven during opcode and address.
- R4: The address phase sends (setup bits 9:8)+1 bytes of the bus offset, MSB first on io0. The offset is truncated to its low bytes when fewer than four are programmed.
- R5: Setup bits 11:10 give a dummy byte count D. The engine issues 8·D SCLK cycles with all four io lines released before data.
- R6: Setup bits 13:12 choose the data lines. 0 samples io1 (one bit per clock). 1 samples io1 as the higher bit and io0 as the lower bit. 3 samples io3 down to io0, with io3 highest. Code 2 behaves like 0. Each received byte arrives MSB first.
- R7: The first received byte lands in bus_rdata[7:0], and the fourth lands in bus_rdata[31:24].
- R8: mm_cs_sel is sampled when a request is accepted. That chip select's setup word is used, and only that chip select goes low. The selection may differ from one access to the next.
- R9: A request with bus_addr+4 greater than WIN_BYTES is refused like R2. The last full word of the window is served.
- R10: bus_done is a one-cycle pulse. For a served read it rises exactly 2·(8+8A+8D+32/W) cycles after the accepting edge, where A is the address byte count, D the dummy byte count and W the line count.
- R11: Setup words for chip select i are written at cfg_addr i. The switch bit is bit 0 written at cfg_addr NUM_CS. Clearing the switch bit makes later reads refused again until the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | 0..NUM_CS-1 selects a setup word; NUM_CS selects the switch |
| cfg_wdata | input | 14 | Setup word, or switch bit in bit 0 |
| mm_cs_sel | input | CS_W | Chip select used for the next mapped read |
| bus_req | input | 1 | Read request, held until bus_done |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_done | output | 1 | One-cycle response pulse |
| bus_err | output | 1 | Response is an error |
| bus_rdata | output | 32 | Read word, valid with bus_done |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_o | output | 4 | io line output values |
| spi_io_oe | output | 4 | io line output enables |
| spi_io_i | input | 4 | io line input values |

## Verification
A wrong header counter or a badly loaded shift register moves every later phase. The flash model would then catch a wrong opcode or address byte, and the word would come back shifted. The done pulse would also rise off its exact expected cycle, which shows within the same read. A wrong lane mode or byte order shows up as wrong data bits on the first read in that mode. A stale chip-select or switch decision shows as a chip select going low on a refused read, or the wrong select being seen by the model, in the cycle after acceptance.

// File: rtl/mmspi_pkg.sv
package mmspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DUMMY,
        ST_DATA,
        ST_FIN,
        ST_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        LN_X1  = 2'd0,
        LN_X2  = 2'd1,
        LN_RSV = 2'd2,
        LN_X4  = 2'd3
    } lane_mode_t;

    // field order sets bit positions: lanes 13:12, dummy 11:10, addr 9:8, opcode 7:0
    typedef struct packed {
        lane_mode_t  lanes;
        logic [1:0]  dummy_bytes;
        logic [1:0]  addr_bytes_m1;
        logic [7:0]  opcode;
    } rd_setup_t;

    localparam int SETUP_W = $bits(rd_setup_t);

endpackage

// File: rtl/mmspi_cfg_regs.sv
module mmspi_cfg_regs
    import mmspi_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CFG_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    output rd_setup_t          setup_tbl [NUM_CS],
    output logic               mm_en
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
        rd_setup_t word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (cfg_wr && cfg_addr == CFG_AW'(g)) begin
                word_q <= rd_setup_t'(cfg_wdata);
            end
        end
        assign setup_tbl[g] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mm_en <= 1'b0;
        end else if (cfg_wr && cfg_addr == CFG_AW'(NUM_CS)) begin
            mm_en <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/mmspi_rx_pack.sv
module mmspi_rx_pack
    import mmspi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        cap,
    input  lane_mode_t  lanes,
    input  logic [3:0]  io_i,
    output logic [31:0] word
);

    logic [31:0] stream_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stream_q <= '0;
        end else if (clear) begin
            stream_q <= '0;
        end else if (cap) begin
            unique case (lanes)
                LN_X4:   stream_q <= {stream_q[27:0], io_i};
                LN_X2:   stream_q <= {stream_q[29:0], io_i[1:0]};
                default: stream_q <= {stream_q[30:0], io_i[1]};
            endcase
        end
    end

    // first byte received sits at the top of the stream; place it in lane 0
    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign word[8*b +: 8] = stream_q[31-8*b -: 8];
    end

endmodule

// File: rtl/mmspi_seq.sv
module mmspi_seq
    import mmspi_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int CS_W      = 2,
    parameter int ADDR_W    = 16,
    parameter int WIN_BYTES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mm_en,
    input  rd_setup_t         cur_setup,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CS_W-1:0]   cs_sel,
    output logic              bus_done,
    output logic              bus_err,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic [3:0]        spi_io_o,
    output logic [3:0]        spi_io_oe,
    output logic              rx_clear,
    output logic              rx_cap,
    output lane_mode_t        rx_lanes
);

    localparam int CNT_W = 6;
    localparam int TX_W  = 40;

    seq_state_t        state_q, state_d;
    logic              phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TX_W-1:0]   tx_q;
    logic [1:0]        dummy_q;
    lane_mode_t        lanes_q;
    logic [CS_W-1:0]   cs_q;

    logic accept, out_of_win, bit_end, last_bit, on_wire;

    function automatic logic [CNT_W-1:0] beats_m1(lane_mode_t m);
        unique case (m)
            LN_X4:   return CNT_W'(7);
            LN_X2:   return CNT_W'(15);
            default: return CNT_W'(31);
        endcase
    endfunction

    assign out_of_win = (33'(bus_addr) + 33'd4) > 33'(WIN_BYTES);
    assign accept     = (state_q == ST_IDLE) && bus_req;
    assign bit_end    = on_wire && phase_q;
    assign last_bit   = bit_end && (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_req) state_d = (!mm_en || out_of_win) ? ST_ERR : ST_HDR;
            ST_HDR:   if (last_bit) state_d = (dummy_q != 2'd0) ? ST_DUMMY : ST_DATA;
            ST_DUMMY: if (last_bit) state_d = ST_DATA;
            ST_DATA:  if (last_bit) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            ST_ERR:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath: shifter, bit counter, latched request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
            tx_q    <= '0;
            dummy_q <= '0;
            lanes_q <= LN_X1;
            cs_q    <= '0;
        end else if (accept) begin
            phase_q <= 1'b0;
            cnt_q   <= CNT_W'({cur_setup.addr_bytes_m1, 3'b000}) + CNT_W'(15);
            tx_q    <= {cur_setup.opcode,
                        32'(bus_addr) << {2'd3 - cur_setup.addr_bytes_m1, 3'b000}};
            dummy_q <= cur_setup.dummy_bytes;
            lanes_q <= cur_setup.lanes;
            cs_q    <= cs_sel;
        end else if (on_wire) begin
            phase_q <= ~phase_q;
            if (bit_end) begin
                if (state_q == ST_HDR) tx_q <= {tx_q[TX_W-2:0], 1'b0};
                if (cnt_q != '0)
                    cnt_q <= cnt_q - CNT_W'(1);
                else if (state_q == ST_HDR && dummy_q != 2'd0)
                    cnt_q <= CNT_W'({dummy_q, 3'b000}) - CNT_W'(1);
                else
                    cnt_q <= beats_m1(lanes_q);
            end
        end else begin
            phase_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        on_wire   = 1'b0;
        bus_done  = 1'b0;
        bus_err   = 1'b0;
        spi_io_oe = 4'b0000;
        unique case (state_q)
            ST_HDR: begin
                on_wire   = 1'b1;
                spi_io_oe = 4'b0001;
            end
            ST_DUMMY, ST_DATA: on_wire = 1'b1;
            ST_FIN:  bus_done = 1'b1;
            ST_ERR: begin
                bus_done = 1'b1;
                bus_err  = 1'b1;
            end
            default: ;
        endcase
    end

    assign spi_sclk = on_wire && phase_q;
    assign spi_io_o = {3'b000, tx_q[TX_W-1]};
    assign rx_clear = accept;
    assign rx_cap   = (state_q == ST_DATA) && phase_q;
    assign rx_lanes = lanes_q;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs_n[g] = !(on_wire && cs_q == CS_W'(g));
    end

endmodule

// File: rtl/mmspi_read_engine.sv
module mmspi_read_engine
    import mmspi_pkg::*;
#(
    parameter  int NUM_CS    = 4,
    parameter  int ADDR_W    = 16,
    parameter  int WIN_BYTES = 32768,
    localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int CFG_AW    = $clog2(NUM_CS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    input  logic [CS_W-1:0]    mm_cs_sel,
    input  logic               bus_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_done,
    output logic               bus_err,
    output logic [31:0]        bus_rdata,
    output logic               spi_sclk,
    output logic [NUM_CS-1:0]  spi_cs_n,
    output logic [3:0]         spi_io_o,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_i
);

    rd_setup_t  setup_tbl [NUM_CS];
    logic       mm_en;
    logic       rx_clear, rx_cap;
    lane_mode_t rx_lanes;

    mmspi_cfg_regs #(.NUM_CS(NUM_CS), .CFG_AW(CFG_AW)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .setup_tbl (setup_tbl),
        .mm_en     (mm_en)
    );

    mmspi_seq #(
        .NUM_CS    (NUM_CS),
        .CS_W      (CS_W),
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mm_en     (mm_en),
        .cur_setup (setup_tbl[mm_cs_sel]),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .cs_sel    (mm_cs_sel),
        .bus_done  (bus_done),
        .bus_err   (bus_err),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_io_o  (spi_io_o),
        .spi_io_oe (spi_io_oe),
        .rx_clear  (rx_clear),
        .rx_cap    (rx_cap),
        .rx_lanes  (rx_lanes)
    );

    mmspi_rx_pack i_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rx_clear),
        .cap   (rx_cap),
        .lanes (rx_lanes),
        .io_i  (spi_io_i),
        .word  (bus_rdata)
    );

endmodule

// File: rtl/mmspi_read_engine_chk.sv
module mmspi_read_engine_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic [3:0]        spi_io_oe,
    input logic              bus_done,
    input logic              bus_err
);

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R8
    cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_cs_n));

    // R5
    sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));

    // R3
    single_line_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_io_oe[3:1] == 3'b000);

    // R2
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_done && (&spi_cs_n) && !spi_sclk));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done);

endmodule

bind mmspi_read_engine mmspi_read_engine_chk #(.NUM_CS(NUM_CS)) i_chk (.*);

// File: tb/test_mmspi_read_engine.sv
module test_mmspi_read_engine;

    localparam int CLK_P  = 10;
    localparam int NUM_CS = 4;
    localparam int ADDR_W = 16;
    localparam int WIN    = 32768;

    logic        clk, rst_n;
    logic        cfg_wr;
    logic [2:0]  cfg_addr;
    logic [13:0] cfg_wdata;
    logic [1:0]  mm_cs_sel;
    logic        bus_req;
    logic [ADDR_W-1:0] bus_addr;
    logic        bus_done, bus_err;
    logic [31:0] bus_rdata;
    logic        spi_sclk;
    logic [3:0]  spi_cs_n, spi_io_o, spi_io_oe, spi_io_i;

    mmspi_read_engine #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WIN_BYTES(WIN)) i_mmspi_read_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mm_cs_sel(mm_cs_sel), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_done(bus_done), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
    );

    int checks = 0;
    int failures = 0;

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    // per-select configuration known to the flash model
    int         m_na [NUM_CS];
    int         m_nd [NUM_CS];
    int         m_mode [NUM_CS];
    logic [7:0] m_op [NUM_CS];

    logic [7:0]  cap_op;
    logic [31:0] cap_addr;
    int          cap_cs;
    bit          cap_seen;
    bit          dummy_bad;
    int          sclk_edges = 0;

    always @(posedge spi_sclk) sclk_edges++;

    function automatic logic [7:0] fbyte(logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // mode-0 flash: samples io0 on rising SCLK, presents data just after rising SCLK
    task automatic model_xfer();
        int cs = 0;
        int w;
        logic [7:0]  op = '0;
        logic [31:0] ad = '0;
        logic [31:0] s;
        for (int i = 0; i < NUM_CS; i++) if (!spi_cs_n[i]) cs = i;
        repeat (8) begin @(posedge spi_sclk); #1; op = {op[6:0], spi_io_o[0]}; end
        repeat (8*m_na[cs]) begin @(posedge spi_sclk); #1; ad = {ad[30:0], spi_io_o[0]}; end
        repeat (8*m_nd[cs]) begin @(posedge spi_sclk); #1; if (spi_io_oe != 4'b0) dummy_bad = 1; end
        w = (m_mode[cs] == 3) ? 4 : (m_mode[cs] == 1) ? 2 : 1;
        s = {fbyte(ad), fbyte(ad + 1), fbyte(ad + 2), fbyte(ad + 3)};
        for (int j = 0; j < 32/w; j++) begin
            @(posedge spi_sclk); #1;
            if (w == 4)      spi_io_i = s[31-4*j -: 4];
            else if (w == 2) spi_io_i = {2'b00, s[31-2*j -: 2]};
            else             spi_io_i = {2'b00, s[31-j], 1'b0};
        end
        cap_op = op; cap_addr = ad; cap_cs = cs; cap_seen = 1;
    endtask

    initial begin
        spi_io_i = 4'h0;
        forever begin
            wait (rst_n && spi_cs_n != 4'hF);
            model_xfer();
            wait (spi_cs_n == 4'hF);
        end
    end

    task automatic cfg_write(input int a, input logic [13:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_cs(input int cs, input logic [7:0] op, input int na, input int nd, input int mode);
        m_op[cs] = op; m_na[cs] = na; m_nd[cs] = nd; m_mode[cs] = mode;
        cfg_write(cs, {2'(mode), 2'(nd), 2'(na - 1), op});
    endtask

    task automatic do_read(input int cs, input logic [31:0] a, output logic [31:0] d,
                           output logic e, output int n);
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0]; mm_cs_sel = 2'(cs); bus_req = 1'b1;
        n = 0; cap_seen = 0; dummy_bad = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!bus_done && n < 5000);
        d = bus_rdata; e = bus_err;
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // served read: checks opcode, address, select, dummy quietness, data and latency
    task automatic read_ok(input int cs, input logic [31:0] a, input string tag);
        logic [31:0] d, at, exp;
        logic e;
        int n, w;
        at  = (m_na[cs] == 4) ? a : (a & ((32'd1 << (8*m_na[cs])) - 1));
        exp = {fbyte(at + 3), fbyte(at + 2), fbyte(at + 1), fbyte(at)};
        w   = (m_mode[cs] == 3) ? 4 : (m_mode[cs] == 1) ? 2 : 1;
        do_read(cs, a, d, e, n);
        chk({tag, " R2 no error"}, 64'(e), 64'd0);
        chk({tag, " R3 opcode"}, 64'(cap_op), 64'(m_op[cs]));
        chk({tag, " R4 address"}, 64'(cap_addr), 64'(at));
        chk({tag, " R5 dummy lines released"}, 64'(dummy_bad), 64'd0);
        chk({tag, " R6 R7 data word"}, 64'(d), 64'(exp));
        chk({tag, " R8 chip select"}, 64'(cap_cs), 64'(cs));
        chk({tag, " R10 latency"}, 64'(n),
            64'(2*(8 + 8*m_na[cs] + 8*m_nd[cs] + 32/w) + 1));
    endtask

    task automatic read_refused(input int cs, input logic [31:0] a, input string tag);
        logic [31:0] d;
        logic e;
        int n, edges0;
        edges0 = sclk_edges;
        do_read(cs, a, d, e, n);
        chk({tag, " error flag"}, 64'(e), 64'd1);
        chk({tag, " one-cycle response"}, 64'(n), 64'd1);
        chk({tag, " no SCLK"}, 64'(sclk_edges - edges0), 64'd0);
        chk({tag, " no select"}, 64'(cap_seen), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 cs_n idle", 64'(spi_cs_n), 64'hF);
        chk("R1 sclk low", 64'(spi_sclk), 64'd0);
        chk("R1 no drive", 64'(spi_io_oe), 64'd0);
        chk("R1 done/err low", 64'({bus_done, bus_err}), 64'd0);
    endtask

    task automatic t_switch_off();
        set_cs(0, 8'h03, 3, 0, 0);
        read_refused(0, 32'h10, "R1 R2 switch clear at reset");
    endtask

    task automatic t_single();
        cfg_write(NUM_CS, 14'h1);
        read_ok(0, 32'h0124, "single 3-byte addr");
        read_ok(0, 32'h5A58, "single second pattern");
    endtask

    task automatic t_dual();
        set_cs(1, 8'h3B, 1, 2, 1);
        read_ok(1, 32'h1238, "dual 1-byte addr truncation");
    endtask

    task automatic t_quad();
        set_cs(2, 8'h6B, 4, 1, 3);
        read_ok(2, 32'h7FFC, "quad last window word R9");
        read_ok(2, 32'h0000, "quad offset zero");
    endtask

    task automatic t_reserved_mode();
        set_cs(3, 8'h0B, 2, 3, 2);
        read_ok(3, 32'h0ABC, "R6 code 2 as single");
    endtask

    task automatic t_cs_alternate();
        read_ok(0, 32'h0040, "R8 alternate select 0");
        read_ok(2, 32'h0044, "R8 alternate select 2");
        read_ok(1, 32'h0048, "R8 alternate select 1");
    endtask

    task automatic t_window();
        read_refused(0, 32'h7FFE, "R9 straddles window end");
        read_refused(2, 32'h8000, "R9 past window");
        read_refused(1, 32'hFFFC, "R9 top of bus range");
    endtask

    task automatic t_switch_back();
        cfg_write(NUM_CS, 14'h0);
        read_refused(0, 32'h0100, "R11 switch cleared");
        cfg_write(NUM_CS, 14'h1);
        read_ok(0, 32'h0100, "R11 switch set again");
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        mm_cs_sel = '0; bus_req = 1'b0; bus_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_switch_off();
        t_single();
        t_dual();
        t_quad();
        t_reserved_mode();
        t_cs_alternate();
        t_window();
        t_switch_back();
        finish_run();
    end

endmodule